// File: doc/BRIEF.md
# Multi-channel MDIO management slave

This block is the serial management slave of a device that carries several transceiver channels. It decodes Clause 22 management frames on the MDC/MDIO pair and gives each channel a small bank of 16-bit configuration registers. A single device answers at four consecutive PHY addresses. The top three address bits must equal a strap-supplied base, and the two low bits pick the channel. The registers load their values from configuration strap pins at reset, so the device runs on its pin settings until software rewrites them. A management-enable strap switches the whole interface off. While it is off, the device never drives the data line and the pin configuration is what the channels use.

MDC and MDIO are oversampled by the local clock `clk`. A small synchronizer turns each rising edge of MDC into a one-cycle strobe that carries the sampled MDIO bit. A frame state machine steps through the following states:

- `ST_PRE`: preamble search.
- `ST_ST1`: the start 0 has been seen.
- `ST_OP`: opcode.
- `ST_PHY`: PHY address.
- `ST_REG`: register address.
- `ST_TA`: turnaround.
- `ST_RD`: the slave shifts read data out.
- `ST_WR`: the slave shifts write data in.

The transitions, each taken on an MDC strobe, are:

- `ST_PRE` to `ST_ST1`: a 0 arrives after a full preamble.
- `ST_ST1` to `ST_OP`: a 1 arrives. A 0 returns the machine to `ST_PRE`.
- `ST_OP` to `ST_PHY`: the opcode is valid. An invalid opcode returns to `ST_PRE`.
- `ST_PHY` to `ST_REG`: the address matches. A mismatch returns to `ST_PRE`.
- `ST_REG` to `ST_TA`: the fifth register address bit has arrived.
- `ST_TA` to `ST_RD` or `ST_WR`: the second turnaround bit has arrived.
- `ST_RD` or `ST_WR` to `ST_PRE`: the last data bit has been handled.

The machine also returns to `ST_PRE` on any clock while the enable is low.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: Frames are sampled on rising MDC edges, with fields sent MSB first, in this order: start bits 0 then 1, a 2-bit opcode (10 = read, 01 = write), a 5-bit PHY address, a 5-bit register address, 2 turnaround bits, then 16 data bits.
- R2: While `mgmt_en` is low, the following hold:
  - `mdio_oe` is 0 from the next clock on.
  - No register is written.
  - `cfg_out` equals `cfg_default` repeated for every channel.
  - When `mgmt_en` returns high, `cfg_out` shows the register contents again, and these are unchanged by frames sent while the enable was low.
- R3: A frame is accepted only when PHY address bits [4:2] equal `phy_base`. Bits [1:0] select channel 0 to 3, and every channel has its own registers.
- R4: After reset, register r of every channel holds `cfg_default[16r+15:16r]`. `cfg_out[(4c+r)*16 +: 16]` shows register r of channel c, and `mdio_oe` is 0.
- R5: An accepted write to register 0 to 3 changes only the addressed register of the addressed channel.
- R6: A start sequence is accepted only after at least 32 consecutive 1 bits. A frame with a 31-bit preamble is ignored.
- R7: On an accepted read, the slave behaves as follows:
  - During the first turnaround bit, `mdio_oe` is 0.
  - During the second turnaround bit, it drives 0.
  - It then drives the 16 data bits MSB first, each changing after a rising MDC edge.
  - It releases the line after the last bit.
- R8: A frame with a non-matching base address, or with opcode 00 or 11, is ignored: nothing is driven and nothing is written. The next frame with a full preamble is served normally.
- R9: Register addresses 4 to 31 are unimplemented. A write to one is discarded, and a read from one drives 16 zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads strap defaults |
| mgmt_en | input | 1 | Management interface enable strap |
| phy_base | input | 3 | Upper PHY address bits strap |
| cfg_default | input | 64 | Register defaults, register r at bits [16r+15:16r] |
| mdc | input | 1 | Management clock |
| mdio_in | input | 1 | Management data from the line |
| mdio_out | output | 1 | Management data to the line |
| mdio_oe | output | 1 | Drive enable for the data line |
| cfg_out | output | 256 | Configuration in effect, channel c register r at [(4c+r)*16 +: 16] |

## Verification
The assertions assume the following about the inputs:
- MDC high and low phases each last several `clk` cycles longer than the synchronizer delay, so that each strobe sees a settled data bit.
- MDIO changes only while MDC is low.
- `mgmt_en` and the straps change only between frames.

The stimulus holds each MDC phase for six clocks and changes MDIO only at the start of a low phase. It toggles the enable only after a frame and its trailing idle bit, and it samples the slave's output just before raising MDC.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_PRE,
        ST_ST1,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_RD,
        ST_WR
    } mdio_state_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam int         ADDR_BITS = 5;

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic rise_o,
    output logic bit_o
);

    logic [STAGES-1:0] mdc_sr;
    logic [STAGES-1:0] dat_sr;
    logic              mdc_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_sr   <= '0;
            dat_sr   <= '1;
            mdc_last <= 1'b0;
        end else begin
            mdc_sr   <= {mdc_sr[STAGES-2:0], mdc_i};
            dat_sr   <= {dat_sr[STAGES-2:0], mdio_i};
            mdc_last <= mdc_sr[STAGES-1];
        end
    end

    assign rise_o = mdc_sr[STAGES-1] & ~mdc_last;
    assign bit_o  = dat_sr[STAGES-1];

    // R1: one strobe per MDC rising edge, never two clocks in a row
    p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/mdio_cfg_regs.sv
module mdio_cfg_regs #(
    parameter int NUM_CH   = 4,
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 16,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int CFG_W   = NUM_REGS * DATA_W,
    localparam int ALL_W   = NUM_CH * CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_default_i,
    input  logic              wr_en_i,
    input  logic [CH_W-1:0]   ch_i,
    input  logic [4:0]        reg_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [ALL_W-1:0]  regs_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            logic [DATA_W-1:0] val_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= cfg_default_i[r*DATA_W +: DATA_W];
                end else if (wr_en_i && ch_i == CH_W'(c) && reg_i == 5'(r)) begin
                    val_q <= wr_data_i;
                end
            end

            assign regs_o[(c*NUM_REGS + r)*DATA_W +: DATA_W] = val_q;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (ch_i == CH_W'(c) && reg_i == 5'(r)) begin
                    rd_data_o = regs_o[(c*NUM_REGS + r)*DATA_W +: DATA_W];
                end
            end
        end
    end

    // R9: writes aimed past the implemented registers leave every register unchanged
    p_unimpl_write_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && int'(reg_i) >= NUM_REGS) |=> $stable(regs_o));

    // R9: unimplemented addresses read as zero
    p_unimpl_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_i) >= NUM_REGS) |-> (rd_data_o == '0));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int CH_W    = 2,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32,
    localparam int BASE_W = ADDR_BITS - CH_W,
    localparam int PCNT_W = $clog2(PRE_LEN + 1),
    localparam int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic              bit_stb_i,
    input  logic              bit_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [CH_W-1:0]   ch_o,
    output logic [4:0]        reg_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              mdio_out_o,
    output logic              mdio_oe_o
);

    mdio_state_e       state_q, state_d;
    logic [PCNT_W-1:0] cnt_q, cnt_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              rd_q, rd_d;
    logic [CH_W-1:0]   ch_q, ch_d;
    logic [4:0]        reg_q, reg_d;
    logic [DATA_W-1:0] shadow_q;
    logic [4:0]        addr5;
    logic [1:0]        op2;

    assign addr5     = {sh_q[3:0], bit_i};
    assign op2       = {sh_q[0], bit_i};
    assign wr_data_o = {sh_q[DATA_W-2:0], bit_i};
    assign ch_o      = ch_q;
    assign reg_o     = reg_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        idx_d   = idx_q;
        rd_d    = rd_q;
        ch_d    = ch_q;
        reg_d   = reg_q;
        wr_en_o = 1'b0;
        if (!en_i) begin
            state_d = ST_PRE;
            cnt_d   = '0;
        end else if (bit_stb_i) begin
            unique case (state_q)
                ST_PRE: begin
                    if (bit_i) begin
                        if (cnt_q != PCNT_W'(PRE_LEN)) cnt_d = cnt_q + 1'b1;
                    end else begin
                        if (cnt_q == PCNT_W'(PRE_LEN)) state_d = ST_ST1;
                        cnt_d = '0;
                    end
                end
                ST_ST1: begin
                    idx_d   = '0;
                    state_d = bit_i ? ST_OP : ST_PRE;
                end
                ST_OP: begin
                    sh_d = {sh_q[DATA_W-2:0], bit_i};
                    if (idx_q == IDX_W'(1)) begin
                        idx_d = '0;
                        if (op2 == OPC_READ) begin
                            rd_d    = 1'b1;
                            state_d = ST_PHY;
                        end else if (op2 == OPC_WRITE) begin
                            rd_d    = 1'b0;
                            state_d = ST_PHY;
                        end else begin
                            state_d = ST_PRE;
                        end
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                ST_PHY: begin
                    sh_d = {sh_q[DATA_W-2:0], bit_i};
                    if (idx_q == IDX_W'(ADDR_BITS - 1)) begin
                        idx_d = '0;
                        if (addr5[4:CH_W] == base_i) begin
                            ch_d    = addr5[CH_W-1:0];
                            state_d = ST_REG;
                        end else begin
                            state_d = ST_PRE;
                        end
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                ST_REG: begin
                    sh_d = {sh_q[DATA_W-2:0], bit_i};
                    if (idx_q == IDX_W'(ADDR_BITS - 1)) begin
                        idx_d   = '0;
                        reg_d   = addr5;
                        state_d = ST_TA;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                ST_TA: begin
                    if (idx_q == '0) begin
                        idx_d = IDX_W'(1);
                    end else if (rd_q) begin
                        idx_d   = IDX_W'(DATA_W - 1);
                        state_d = ST_RD;
                    end else begin
                        idx_d   = '0;
                        state_d = ST_WR;
                    end
                end
                ST_RD: begin
                    if (idx_q == '0) state_d = ST_PRE;
                    else             idx_d   = idx_q - 1'b1;
                end
                ST_WR: begin
                    sh_d = {sh_q[DATA_W-2:0], bit_i};
                    if (idx_q == IDX_W'(DATA_W - 1)) begin
                        wr_en_o = 1'b1;
                        idx_d   = '0;
                        state_d = ST_PRE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                default: state_d = ST_PRE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRE;
            cnt_q   <= '0;
            sh_q    <= '0;
            idx_q   <= '0;
            rd_q    <= 1'b0;
            ch_q    <= '0;
            reg_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            idx_q   <= idx_d;
            rd_q    <= rd_d;
            ch_q    <= ch_d;
            reg_q   <= reg_d;
        end
    end

    // line drive outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_oe_o  <= 1'b0;
            mdio_out_o <= 1'b1;
            shadow_q   <= '0;
        end else if (!en_i) begin
            mdio_oe_o  <= 1'b0;
            mdio_out_o <= 1'b1;
        end else if (bit_stb_i) begin
            if (state_q == ST_TA && rd_q) begin
                if (idx_q == '0) begin
                    mdio_oe_o  <= 1'b1;
                    mdio_out_o <= 1'b0;
                end else begin
                    mdio_out_o <= rd_data_i[DATA_W-1];
                    shadow_q   <= rd_data_i;
                end
            end else if (state_q == ST_RD) begin
                if (idx_q == '0) begin
                    mdio_oe_o  <= 1'b0;
                    mdio_out_o <= 1'b1;
                end else begin
                    mdio_out_o <= shadow_q[idx_q - 1'b1];
                end
            end else begin
                mdio_oe_o <= 1'b0;
            end
        end
    end

    // R2: the line is released once the enable is low
    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !mdio_oe_o);

    // R7: first turnaround bit is never driven
    p_ta1_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TA && idx_q == '0) |-> !mdio_oe_o);

    // R7: second turnaround bit is driven low
    p_ta2_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TA && idx_q != '0 && mdio_oe_o) |-> !mdio_out_o);

    // R8: drive happens only inside a read's turnaround or data phase
    p_drive_in_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe_o |-> (state_q == ST_TA || state_q == ST_RD));

    // R7: line released after the last data bit
    p_release_after_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD && idx_q == '0 && bit_stb_i) |=> !mdio_oe_o);

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
    parameter int NUM_CH      = 4,
    parameter int NUM_REGS    = 4,
    parameter int DATA_W      = 16,
    parameter int PRE_LEN     = 32,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int BASE_W     = mdio_pkg::ADDR_BITS - CH_W,
    localparam int CFG_W      = NUM_REGS * DATA_W,
    localparam int ALL_W      = NUM_CH * CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_en,
    input  logic [BASE_W-1:0] phy_base,
    input  logic [CFG_W-1:0]  cfg_default,
    input  logic              mdc,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic [ALL_W-1:0]  cfg_out
);

    logic              bit_stb;
    logic              bit_val;
    logic [CH_W-1:0]   ch_sel;
    logic [4:0]        reg_sel;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [ALL_W-1:0]  regs_all;

    mdio_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .mdc_i  (mdc),
        .mdio_i (mdio_in),
        .rise_o (bit_stb),
        .bit_o  (bit_val)
    );

    mdio_frame_fsm #(
        .CH_W    (CH_W),
        .DATA_W  (DATA_W),
        .PRE_LEN (PRE_LEN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (mgmt_en),
        .base_i     (phy_base),
        .bit_stb_i  (bit_stb),
        .bit_i      (bit_val),
        .rd_data_i  (rd_data),
        .ch_o       (ch_sel),
        .reg_o      (reg_sel),
        .wr_en_o    (wr_en),
        .wr_data_o  (wr_data),
        .mdio_out_o (mdio_out),
        .mdio_oe_o  (mdio_oe)
    );

    mdio_cfg_regs #(
        .NUM_CH   (NUM_CH),
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_default_i (cfg_default),
        .wr_en_i       (wr_en),
        .ch_i          (ch_sel),
        .reg_i         (reg_sel),
        .wr_data_i     (wr_data),
        .rd_data_o     (rd_data),
        .regs_o        (regs_all)
    );

    assign cfg_out = mgmt_en ? regs_all : {NUM_CH{cfg_default}};

    // R2: no register changes while the interface is disabled
    p_no_write_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_en |=> $stable(regs_all));

endmodule

// File: tb/tb_mdio_mgmt_slave.sv
module tb_mdio_mgmt_slave;

    localparam int HALF = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mgmt_en = 1'b1;
    logic [2:0]   phy_base = 3'b101;
    logic [63:0]  cfg_default = 64'h0F0F_3C5A_8001_1234;
    logic         mdc = 1'b0;
    logic         mdio_in = 1'b1;
    logic         mdio_out;
    logic         mdio_oe;
    logic [255:0] cfg_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [15:0] model [4][4];

    // results of the last frame
    logic [15:0] r_data;
    logic        r_hdr_oe, r_ta1_oe, r_ta2_oe, r_ta2_out, r_dat_all, r_dat_any, r_post_oe;

    always #2 clk = ~clk;

    mdio_mgmt_slave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mgmt_en     (mgmt_en),
        .phy_base    (phy_base),
        .cfg_default (cfg_default),
        .mdc         (mdc),
        .mdio_in     (mdio_in),
        .mdio_out    (mdio_out),
        .mdio_oe     (mdio_oe),
        .cfg_out     (cfg_out)
    );

    function automatic logic [255:0] model_flat();
        logic [255:0] v;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                v[(c*4 + r)*16 +: 16] = model[c][r];
        return v;
    endfunction

    function automatic logic [15:0] exp_read(input int ch, input int rg);
        return (rg < 4) ? model[ch][rg] : 16'h0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_io(input logic b, output logic so, output logic soe);
        @(negedge clk);
        mdio_in = b;
        mdc = 1'b0;
        repeat (HALF - 1) @(negedge clk);
        so  = mdio_out;
        soe = mdio_oe;
        @(negedge clk);
        mdc = 1'b1;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] wd, input bit is_rd);
        logic so, soe;
        logic [13:0] hdr;
        hdr = {2'b01, op, phy, rg};
        r_hdr_oe = 0; r_dat_all = 1; r_dat_any = 0; r_data = '0;
        for (int i = 0; i < pre; i++) begin
            bit_io(1'b1, so, soe);
            r_hdr_oe |= soe;
        end
        for (int i = 13; i >= 0; i--) begin
            bit_io(hdr[i], so, soe);
            r_hdr_oe |= soe;
        end
        bit_io(1'b1, so, soe);
        r_ta1_oe = soe;
        bit_io(is_rd ? 1'b1 : 1'b0, so, soe);
        r_ta2_oe = soe; r_ta2_out = so;
        for (int i = 15; i >= 0; i--) begin
            bit_io(is_rd ? 1'b1 : wd[i], so, soe);
            r_data[i] = so;
            r_dat_all &= soe;
            r_dat_any |= soe;
        end
        bit_io(1'b1, so, soe);
        r_post_oe = soe;
    endtask

    task automatic do_write(input logic [2:0] base, input int ch, input int rg, input logic [15:0] wd);
        frame(32, 2'b01, {base, 2'(ch)}, 5'(rg), wd, 1'b0);
        if (mgmt_en && base == phy_base && rg < 4) model[ch][rg] = wd;
    endtask

    // valid read: full timing and data check
    task automatic read_chk(input int ch, input int rg, input string req);
        logic [15:0] e;
        e = exp_read(ch, rg);
        frame(32, 2'b10, {phy_base, 2'(ch)}, 5'(rg), 16'h0, 1'b1);
        chk(!r_hdr_oe && !r_ta1_oe && r_ta2_oe && !r_ta2_out && r_dat_all && !r_post_oe,
            "R7 turnaround/drive timing",
            {r_hdr_oe, r_ta1_oe, r_ta2_oe, r_ta2_out, r_dat_all, r_post_oe}, 6'b001010);
        chk(r_data == e, req, r_data, e);
    endtask

    task automatic cfg_chk(input string req);
        chk(cfg_out == model_flat(), req, cfg_out, model_flat());
    endtask

    initial begin
        logic so, soe;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                model[c][r] = cfg_default[r*16 +: 16];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4: reset state
        chk(mdio_oe == 1'b0, "R4 oe after reset", mdio_oe, 0);
        cfg_chk("R4 defaults after reset");

        // R1 R7: plain read of channel 0 register 0
        read_chk(0, 0, "R1 read default ch0 reg0");

        // R5 R3: write one register, others intact
        do_write(phy_base, 2, 1, 16'hA5C3);
        cfg_chk("R5 write touches only ch2 reg1");
        read_chk(2, 1, "R3 read back ch2 reg1");
        read_chk(1, 1, "R3 ch1 reg1 still default");

        // R9: unimplemented register
        do_write(phy_base, 3, 7, 16'h1234);
        cfg_chk("R9 write to reg7 discarded");
        read_chk(3, 7, "R9 reg7 reads zero");
        read_chk(3, 31, "R9 reg31 reads zero");

        // R8: wrong base address
        do_write(3'b010, 1, 2, 16'hDEAD);
        cfg_chk("R8 wrong base write ignored");
        frame(32, 2'b10, {3'b010, 2'd1}, 5'd2, 16'h0, 1'b1);
        chk(!(r_hdr_oe | r_ta1_oe | r_ta2_oe | r_dat_any | r_post_oe), "R8 wrong base read not driven",
            r_dat_any, 0);

        // R8: invalid opcodes
        frame(32, 2'b11, {phy_base, 2'd0}, 5'd0, 16'hBEEF, 1'b0);
        cfg_chk("R8 opcode 11 ignored");
        frame(32, 2'b00, {phy_base, 2'd1}, 5'd3, 16'hCAFE, 1'b0);
        cfg_chk("R8 opcode 00 ignored");
        read_chk(1, 3, "R8 served after invalid frame");

        // R6: preamble length
        bit_io(1'b0, so, soe);
        frame(31, 2'b01, {phy_base, 2'd0}, 5'd2, 16'h7777, 1'b0);
        cfg_chk("R6 31-bit preamble ignored");
        bit_io(1'b0, so, soe);
        frame(32, 2'b01, {phy_base, 2'd0}, 5'd2, 16'h7777, 1'b0);
        model[0][2] = 16'h7777;
        cfg_chk("R6 32-bit preamble accepted");

        // R2: disabled interface
        mgmt_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(cfg_out == {4{cfg_default}}, "R2 pin config while disabled", cfg_out, {4{cfg_default}});
        do_write(phy_base, 0, 2, 16'h4242);
        frame(32, 2'b10, {phy_base, 2'd0}, 5'd2, 16'h0, 1'b1);
        chk(!(r_hdr_oe | r_ta1_oe | r_ta2_oe | r_dat_any | r_post_oe), "R2 no drive while disabled",
            r_dat_any, 0);
        mgmt_en = 1'b1;
        repeat (2) @(negedge clk);
        cfg_chk("R2 registers unchanged after disable");
        read_chk(0, 2, "R2 register value kept");

        // random mix, fixed seed
        void'($urandom(32'd4711));
        for (int n = 0; n < 40; n++) begin
            int ch, rg;
            logic [2:0] base;
            ch   = int'($urandom_range(3, 0));
            rg   = int'($urandom_range(5, 0));
            base = ($urandom_range(7, 0) == 0) ? ~phy_base : phy_base;
            if ($urandom_range(1, 0) == 1) begin
                do_write(base, ch, rg, 16'($urandom));
                cfg_chk("R5 random write");
            end else if (base == phy_base) begin
                read_chk(ch, rg, "R3 random read");
            end else begin
                frame(32, 2'b10, {base, 2'(ch)}, 5'(rg), 16'h0, 1'b1);
                chk(!(r_ta2_oe | r_dat_any), "R8 random wrong base", r_dat_any, 0);
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule